// File: doc/BRIEF.md
# E3 Receive Alarm Integrator with Control/Status Registers

This block sits behind an E3 receive framer and turns per-frame indications into debounced alarm states. On every frame strobe it looks at the received far-end alarm bit and the framer's out-of-frame flag. Each of the two alarms has its own hysteresis integrator. An alarm is declared only after a run of consecutive frames that disagree with the present state, and it is cleared only after a run of the same length in the opposite direction.

Two byte-wide registers on a plain read/write microprocessor bus hold the persistence selects and the BIP-4 reporting enable. They also return the live alarm and line status. Frame alignment, BIP-4 computation and LOS/AIS detection happen upstream, and their results arrive here as already-decoded inputs.

Top module: `e3_rx_alarm_regs`

## Requirements
- R1: With the far-end alarm select at 0, `ferf_o` rises after 3 consecutive frame strobes with `a_bit_i`=1, and falls after 3 consecutive strobes with `a_bit_i`=0.
- R2: With the far-end alarm select at 1, both the declare run and the clear run for `ferf_o` are 5 consecutive strobes.
- R3: With the loss-of-frame select at 0, `lof_o` rises after 24 consecutive strobes with `oof_i`=1, and falls after 24 consecutive strobes with `oof_i`=0.
- R4: With the loss-of-frame select at 1, both the declare run and the clear run for `lof_o` are 8 consecutive strobes.
- R5: Counting happens only on cycles with `frame_stb_i`=1. Any strobe whose value matches the current alarm state restarts the run from zero. The alarm state changes on the clock edge that samples the strobe completing the run.
- R6: When a select bit changes, the matching run count restarts on the following clock and that clock's strobe is not counted. The alarm already held is kept until a full run at the new length has been seen.
- R7: Address 0x10 holds the far-end alarm select in bit 4 and the BIP-4 enable in bit 0. Both are read/write and reset to 0. Every other bit of this register reads 0.
- R8: Address 0x11 holds the loss-of-frame select in bit 7 (read/write, reset 0). It returns the LOF state in bit 6, `oof_i` in bit 5, `los_i` in bit 4, `ais_i` in bit 3 and the FERF state in bit 0. Bits 2 and 1 read 0, and writes to the status bits have no effect.
- R9: A read with `rd_i`=1 loads `rdata_o` on that clock edge. `rdata_o` holds its value while no read is active. Any other address reads 0x00.
- R10: `bip_err_o` pulses for one clock after a strobe that carries `bip_err_i`=1, and only while the BIP-4 enable is 1. While the enable is 0, BIP-4 errors are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe per received E3 frame |
| a_bit_i | input | 1 | Received far-end alarm bit, valid with the strobe |
| oof_i | input | 1 | Framer out-of-frame flag |
| los_i | input | 1 | Loss of signal indication |
| ais_i | input | 1 | Alarm indication signal detected |
| bip_err_i | input | 1 | BIP-4 mismatch for this frame, valid with the strobe |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ferf_o | output | 1 | Debounced far-end receive failure state |
| lof_o | output | 1 | Debounced loss-of-frame state |
| bip_err_o | output | 1 | Gated BIP-4 error pulse |

## Verification
The hardest case to reach is a select change that lands partway through a run. Without the restart, the run would cross the new threshold one frame early, and a different frame would complete it. The stimulus first feeds two alarm frames, then switches the FERF persistence from 3 to 5 through the bus. It then applies four more alarm frames and expects no declaration, because an unrestarted count of six would already have declared. A fifth frame must then declare. Sweeps of run length around every threshold in both selects, including runs broken by a single opposite frame, cover the off-by-one edges of the counters.

// File: rtl/e3_alm_pkg.sv
package e3_alm_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] ADDR_CFG  = 8'h10;
  localparam logic [AW-1:0] ADDR_STAT = 8'h11;
  // cfg register bit positions
  localparam int unsigned B_FERF_SEL = 4;
  localparam int unsigned B_BIP_EN   = 0;
  // stat register bit positions
  localparam int unsigned B_LOF_SEL  = 7;
  localparam int unsigned B_LOF      = 6;
  localparam int unsigned B_OOF      = 5;
  localparam int unsigned B_LOS      = 4;
  localparam int unsigned B_AIS      = 3;
  localparam int unsigned B_FERF     = 0;
  // persistence thresholds, index by select bit
  localparam int unsigned FERF_TH0 = 3;
  localparam int unsigned FERF_TH1 = 5;
  localparam int unsigned LOF_TH0  = 24;
  localparam int unsigned LOF_TH1  = 8;

  typedef struct packed {
    logic ferf_sel;
    logic bip_en;
    logic lof_sel;
  } alm_cfg_t;
endpackage

// File: rtl/e3_persist_integ.sv
module e3_persist_integ #(
  parameter int unsigned TH0 = 3,
  parameter int unsigned TH1 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic level_i,
  input  logic sel_i,
  output logic state_o
);
  localparam int unsigned TH_MAX = (TH0 > TH1) ? TH0 : TH1;
  localparam int unsigned CW     = $clog2(TH_MAX + 1);
  localparam logic [CW-1:0] LAST0 = CW'(TH0 - 1);
  localparam logic [CW-1:0] LAST1 = CW'(TH1 - 1);

  logic          sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = sel_q ? LAST1 : LAST0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      cnt_q   <= '0;
      state_o <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (sel_i != sel_q) begin
        cnt_q <= '0;                 // threshold changed: restart run
      end else if (stb_i) begin
        if (level_i == state_o) begin
          cnt_q <= '0;
        end else if (cnt_q == last) begin
          state_o <= level_i;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/e3_alm_regs.sv
module e3_alm_regs
  import e3_alm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ferf_i,
  input  logic          lof_i,
  input  logic          oof_i,
  input  logic          los_i,
  input  logic          ais_i,
  output alm_cfg_t      cfg_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] cfg_byte, stat_byte, rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CFG) begin
        cfg_o.ferf_sel <= wdata_i[B_FERF_SEL];
        cfg_o.bip_en   <= wdata_i[B_BIP_EN];
      end
      if (addr_i == ADDR_STAT) cfg_o.lof_sel <= wdata_i[B_LOF_SEL];
    end
  end

  always_comb begin
    cfg_byte              = '0;
    cfg_byte[B_FERF_SEL]  = cfg_o.ferf_sel;
    cfg_byte[B_BIP_EN]    = cfg_o.bip_en;
    stat_byte             = '0;
    stat_byte[B_LOF_SEL]  = cfg_o.lof_sel;
    stat_byte[B_LOF]      = lof_i;
    stat_byte[B_OOF]      = oof_i;
    stat_byte[B_LOS]      = los_i;
    stat_byte[B_AIS]      = ais_i;
    stat_byte[B_FERF]     = ferf_i;
    case (addr_i)
      ADDR_CFG:  rd_mux = cfg_byte;
      ADDR_STAT: rd_mux = stat_byte;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/e3_rx_alarm_regs.sv
module e3_rx_alarm_regs
  import e3_alm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_stb_i,
  input  logic          a_bit_i,
  input  logic          oof_i,
  input  logic          los_i,
  input  logic          ais_i,
  input  logic          bip_err_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ferf_o,
  output logic          lof_o,
  output logic          bip_err_o
);
  alm_cfg_t cfg;

  e3_alm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ferf_i  (ferf_o),
    .lof_i   (lof_o),
    .oof_i   (oof_i),
    .los_i   (los_i),
    .ais_i   (ais_i),
    .cfg_o   (cfg),
    .rdata_o (rdata_o)
  );

  e3_persist_integ #(.TH0(FERF_TH0), .TH1(FERF_TH1)) u_ferf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (frame_stb_i),
    .level_i (a_bit_i),
    .sel_i   (cfg.ferf_sel),
    .state_o (ferf_o)
  );

  e3_persist_integ #(.TH0(LOF_TH0), .TH1(LOF_TH1)) u_lof (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (frame_stb_i),
    .level_i (oof_i),
    .sel_i   (cfg.lof_sel),
    .state_o (lof_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bip_err_o <= 1'b0;
    else         bip_err_o <= frame_stb_i & bip_err_i & cfg.bip_en;
  end
endmodule

// File: rtl/e3_rx_alarm_regs_chk.sv
module e3_rx_alarm_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_stb_i,
  input logic       a_bit_i,
  input logic       oof_i,
  input logic       bip_err_i,
  input logic       rd_i,
  input logic [7:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       ferf_o,
  input logic       lof_o,
  input logic       bip_err_o
);
  p_ferf_on_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferf_o != $past(ferf_o)) |-> $past(frame_stb_i));
  p_lof_on_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lof_o != $past(lof_o)) |-> $past(frame_stb_i));
  p_ferf_rise_abit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ferf_o) |-> $past(a_bit_i));
  p_ferf_fall_abit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ferf_o) |-> !$past(a_bit_i));
  p_lof_rise_oof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lof_o) |-> $past(oof_i));
  p_lof_fall_inframe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lof_o) |-> !$past(oof_i));
  p_bip_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bip_err_o |-> $past(frame_stb_i && bip_err_i));
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
  p_cfg_zero_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && addr_i == 8'h10) |-> (rdata_o[7:5] == 3'b0 && rdata_o[3:1] == 3'b0));
  p_stat_zero_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && addr_i == 8'h11) |-> (rdata_o[2:1] == 2'b0));
endmodule

bind e3_rx_alarm_regs e3_rx_alarm_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_stb_i (frame_stb_i),
  .a_bit_i     (a_bit_i),
  .oof_i       (oof_i),
  .bip_err_i   (bip_err_i),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .ferf_o      (ferf_o),
  .lof_o       (lof_o),
  .bip_err_o   (bip_err_o)
);

// File: tb/sim_e3_rx_alarm_regs.sv
`timescale 1ns/1ps
module sim_e3_rx_alarm_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, abit = 1'b0, oof = 1'b0, los = 1'b0, ais = 1'b0, bip = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       ferf, lof, bip_o;
  logic       last_bip;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  e3_rx_alarm_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(stb), .a_bit_i(abit), .oof_i(oof),
    .los_i(los), .ais_i(ais), .bip_err_i(bip), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ferf_o(ferf), .lof_o(lof),
    .bip_err_o(bip_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one frame: strobe for one clock, capture bip_err_o right after the edge
  task automatic frame(input logic a, input logic o, input logic b);
    @(negedge clk); stb = 1'b1; abit = a; oof = o; bip = b;
    @(posedge clk); #1 last_bip = bip_o;
    @(negedge clk); stb = 1'b0; bip = 1'b0;
  endtask

  task automatic frames(input int n, input logic a, input logic o);
    for (int i = 0; i < n; i++) frame(a, o, 1'b0);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int th;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R7 reset ferf", {7'b0, ferf}, 8'h00);
    chk("R3 reset lof", {7'b0, lof}, 8'h00);
    rd_reg(8'h10, d); chk("R7 reset cfg", d, 8'h00);
    rd_reg(8'h11, d); chk("R8 reset stat", d, 8'h00);

    // FERF run-length sweep, both selects
    for (int s = 0; s < 2; s++) begin
      wr_reg(8'h10, s ? 8'h10 : 8'h00);
      th = s ? 5 : 3;
      for (int n = 1; n <= 7; n++) begin
        frames(n, 1'b1, 1'b0);
        chk(s ? "R2 ferf declare" : "R1 ferf declare", {7'b0, ferf}, {7'b0, n >= th});
        if (n >= th) begin
          frames(th - 1, 1'b0, 1'b0);
          chk(s ? "R2 ferf hold" : "R1 ferf hold", {7'b0, ferf}, 8'h01);
          frame(1'b0, 1'b0, 1'b0);
          chk(s ? "R2 ferf clear" : "R1 ferf clear", {7'b0, ferf}, 8'h00);
        end else frames(1, 1'b0, 1'b0);
      end
    end

    // LOF run-length sweep around both thresholds
    for (int s = 0; s < 2; s++) begin
      wr_reg(8'h11, s ? 8'h80 : 8'h00);
      th = s ? 8 : 24;
      for (int n = th - 2; n <= th + 1; n++) begin
        frames(n, 1'b0, 1'b1);
        chk(s ? "R4 lof declare" : "R3 lof declare", {7'b0, lof}, {7'b0, n >= th});
        if (n >= th) begin
          frames(th - 1, 1'b0, 1'b0);
          chk(s ? "R4 lof hold" : "R3 lof hold", {7'b0, lof}, 8'h01);
          frame(1'b0, 1'b0, 1'b0);
          chk(s ? "R4 lof clear" : "R3 lof clear", {7'b0, lof}, 8'h00);
        end else frames(1, 1'b0, 1'b0);
      end
    end
    wr_reg(8'h11, 8'h00);

    // R5: no counting without strobe, broken run restarts
    wr_reg(8'h10, 8'h00);
    @(negedge clk); abit = 1'b1; oof = 1'b1;
    repeat (30) @(negedge clk);
    chk("R5 no strobe ferf", {7'b0, ferf}, 8'h00);
    chk("R5 no strobe lof", {7'b0, lof}, 8'h00);
    abit = 1'b0; oof = 1'b0;
    frames(2, 1'b1, 1'b0); frame(1'b0, 1'b0, 1'b0); frames(2, 1'b1, 1'b0);
    chk("R5 broken run", {7'b0, ferf}, 8'h00);
    frame(1'b1, 1'b0, 1'b0);
    chk("R5 run complete", {7'b0, ferf}, 8'h01);
    frames(3, 1'b0, 1'b0);
    chk("R5 cleared", {7'b0, ferf}, 8'h00);

    // R6: select change mid-run restarts the count
    frames(2, 1'b1, 1'b0);
    wr_reg(8'h10, 8'h10);
    frames(4, 1'b1, 1'b0);
    chk("R6 restart no early declare", {7'b0, ferf}, 8'h00);
    frame(1'b1, 1'b0, 1'b0);
    chk("R6 declare after full run", {7'b0, ferf}, 8'h01);
    wr_reg(8'h10, 8'h00);
    chk("R6 state kept over select change", {7'b0, ferf}, 8'h01);
    frames(2, 1'b0, 1'b0);
    chk("R6 hold below new threshold", {7'b0, ferf}, 8'h01);
    frame(1'b0, 1'b0, 1'b0);
    chk("R6 clear at new threshold", {7'b0, ferf}, 8'h00);

    // R7: cfg register layout
    wr_reg(8'h10, 8'hFF); rd_reg(8'h10, d); chk("R7 cfg all ones", d, 8'h11);
    wr_reg(8'h10, 8'hEE); rd_reg(8'h10, d); chk("R7 cfg pattern", d, 8'h00);

    // R8: status layout, read-only bits ignore writes
    frames(3, 1'b1, 1'b0);
    @(negedge clk); oof = 1'b1; los = 1'b0; ais = 1'b1;
    wr_reg(8'h11, 8'hFF); rd_reg(8'h11, d); chk("R8 stat sel+live", d, 8'hA9);
    @(negedge clk); oof = 1'b0; los = 1'b1; ais = 1'b0;
    wr_reg(8'h11, 8'h7F); rd_reg(8'h11, d); chk("R8 ro bits ignore write", d, 8'h11);
    frames(3, 1'b0, 1'b0);

    // R9: hold when idle, unmapped address
    rd_reg(8'h11, d);
    @(negedge clk); los = 1'b0; ais = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 rdata holds", rdata, 8'h10);
    rd_reg(8'h12, d); chk("R9 unmapped", d, 8'h00);
    rd_reg(8'h00, d); chk("R9 unmapped low", d, 8'h00);
    ais = 1'b0;

    // R10: bip gating
    wr_reg(8'h10, 8'h00);
    frame(1'b0, 1'b0, 1'b1); chk("R10 bip disabled", {7'b0, last_bip}, 8'h00);
    wr_reg(8'h10, 8'h01);
    frame(1'b0, 1'b0, 1'b1); chk("R10 bip enabled", {7'b0, last_bip}, 8'h01);
    @(posedge clk); #1 chk("R10 bip one cycle", {7'b0, bip_o}, 8'h00);
    frame(1'b0, 1'b0, 1'b0); chk("R10 no error", {7'b0, last_bip}, 8'h00);
    @(negedge clk); bip = 1'b1;
    @(posedge clk); #1 chk("R10 no strobe no pulse", {7'b0, bip_o}, 8'h00);
    @(negedge clk); bip = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule